// File: doc/BRIEF.md
# Feedback Divider Ramp Sequencer

This block changes the feedback multiplier N of a PLL that is already running, and it does so without a step in the output frequency. It keeps a small register model made of four words: a coefficient word, two step-size configuration words and a slowdown/ramp control word. When a start strobe arrives together with a requested N, the block runs a fixed sequence. It loads the ramp step sizes, enters slowdown mode, writes the new N, enables the hardware ramp, polls a ramp-finished status input and then leaves slowdown mode.

The analog ramp is represented only by the asynchronous `ramp_fin_i` input. The block does not choose the coefficients. If the requested N is already programmed, the whole sequence is skipped. The status input is polled a bounded number of times. If it never reports completion, the sequence still exits cleanly and raises an error flag.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are low. `coef_o` equals the parameter `COEF_RST`, and `stepa_o`, `stepb_o` and `slow_o` are zero. In the coefficient word, M is bits 7:0, N is bits 15:8 and PL is bits 21:16.
- R2: If `start_i` is sampled while idle and `ndiv_i` equals `coef_o[15:8]`, then `done_o` is high for exactly the next cycle. `busy_o` stays low and none of the four register words changes.
- R3: A ramp sequence first sets `stepa_o[31:24]` to 0x2B and `stepb_o[23:16]` to 0x0B. All other bits of those two words are left alone.
- R4: Slowdown mode (`slow_o[22]`) is set before N (`coef_o[15:8]`) takes the requested value. M and PL stay unchanged.
- R5: The ramp enable (`slow_o[31]`) rises only after the new N is in place, and only while slowdown mode is set.
- R6: `ramp_fin_i` passes through a two-flop synchronizer. One poll is taken every `POLL_GAP` cycles, and there are at most `MAX_POLLS` polls. If a poll sees the status high, the sequence ends with a one-cycle `done_o`.
- R7: If `MAX_POLLS` polls all fail, the sequence ends with a one-cycle `err_o`. That pulse comes `MAX_POLLS*POLL_GAP+1` cycles after `slow_o[31]` rises, and the requested N stays written.
- R8: On either outcome, `slow_o[22]` and `slow_o[31]` are cleared in the same cycle, and that is the cycle in which `done_o` or `err_o` is high.
- R9: `busy_o` is high from the cycle after an accepted start until the `done_o`/`err_o` cycle. A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a change of N |
| ndiv_i | input | 8 | Requested N |
| ramp_fin_i | input | 1 | Asynchronous ramp-finished status |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| coef_o | output | 32 | Coefficient word (M, N, PL) |
| stepa_o | output | 32 | Step configuration word A |
| stepb_o | output | 32 | Step configuration word B |
| slow_o | output | 32 | Slowdown/ramp control word |

## Verification
The assertions check the ordering rules on every cycle:
- N never changes outside slowdown mode.
- The ramp enable rises only with N already stable.
- The two control bits fall together.
- The done and error pulses never coincide, and neither overlaps busy.
- A matching request is answered in one cycle without touching any register.

Some behaviour only the bench scenarios can show. These are the exact step-field values, the timeout latency counted against the poll parameters, the outcome under different status delays, and that a start issued mid-sequence leaves the result untouched.

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl #(
  parameter int          MAX_POLLS = 500,
  parameter int          POLL_GAP  = 16,
  parameter logic [31:0] COEF_RST  = 32'h0001_2801
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  ndiv_i,
  input  logic        ramp_fin_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] coef_o,
  output logic [31:0] stepa_o,
  output logic [31:0] stepb_o,
  output logic [31:0] slow_o
);
  localparam int TW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_POLLS - 1);
  localparam logic [GW-1:0] LAST_GAP = GW'(POLL_GAP - 1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_SLOW, S_LOAD, S_RAMP, S_POLL, S_EXIT} st_t;

  st_t           st;
  logic [7:0]    tgt;
  logic [TW-1:0] tries;
  logic [GW-1:0] gap;
  logic          ok;
  logic [1:0]    sync;

  assign busy_o = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], ramp_fin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tgt     <= '0;
      tries   <= '0;
      gap     <= '0;
      ok      <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      coef_o  <= COEF_RST;
      stepa_o <= '0;
      stepb_o <= '0;
      slow_o  <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st)
        S_IDLE:
          if (start_i) begin
            if (ndiv_i == coef_o[15:8]) done_o <= 1'b1;
            else begin
              tgt <= ndiv_i;
              st  <= S_STEP;
            end
          end
        S_STEP: begin
          stepa_o[31:24] <= 8'h2B;
          stepb_o[23:16] <= 8'h0B;
          st <= S_SLOW;
        end
        S_SLOW: begin
          slow_o[22] <= 1'b1;
          st <= S_LOAD;
        end
        S_LOAD: begin
          coef_o[15:8] <= tgt;
          st <= S_RAMP;
        end
        S_RAMP: begin
          slow_o[31] <= 1'b1;
          tries <= '0;
          gap   <= '0;
          st    <= S_POLL;
        end
        S_POLL:
          if (gap != LAST_GAP) gap <= gap + 1'b1;
          else begin
            gap <= '0;
            if (sync[1]) begin
              ok <= 1'b1;
              st <= S_EXIT;
            end else if (tries == LAST_TRY) begin
              ok <= 1'b0;
              st <= S_EXIT;
            end else tries <= tries + 1'b1;
          end
        S_EXIT: begin
          slow_o[22] <= 1'b0;
          slow_o[31] <= 1'b0;
          done_o <= ok;
          err_o  <= !ok;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ndiv_ramp_ctrl_chk.sv
module ndiv_ramp_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [7:0]  ndiv_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] coef_o,
  input logic [31:0] slow_o
);
  p_skip_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && ndiv_i == coef_o[15:8]) |=> (done_o && !busy_o && $stable(coef_o) && $stable(slow_o)));

  p_n_in_slowdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coef_o[15:8]) |-> (slow_o[22] && $past(slow_o[22]) && !slow_o[31]));

  p_ramp_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_o[31]) |-> (slow_o[22] && $stable(coef_o[15:8])));

  p_exit_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_o[22]) |-> ($fell(slow_o[31]) && (done_o || err_o)));

  p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o) && !((done_o || err_o) && busy_o));
endmodule

bind ndiv_ramp_ctrl ndiv_ramp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ndiv_i(ndiv_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .coef_o(coef_o), .slow_o(slow_o)
);

// File: tb/test_ndiv_ramp_ctrl.sv
module test_ndiv_ramp_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          NPOLL = 500;
  localparam int          GAP   = 4;
  localparam logic [31:0] RST_COEF = 32'h0001_2801;

  typedef struct packed { logic [7:0] n; int dly; logic e; } vec_t;
  localparam vec_t VECS [4] = '{
    '{8'h40, 3, 1'b0}, '{8'h10, 20, 1'b0}, '{8'hFF, 0, 1'b0}, '{8'h33, -1, 1'b1}
  };

  logic clk = 0, rst_n = 0, start = 0, fin = 0;
  logic [7:0] ndiv = 0;
  logic busy, done, err;
  logic [31:0] coef, stepa, stepb, slow;
  int total = 0, bad = 0, dly = -1, wcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ndiv_ramp_ctrl #(.MAX_POLLS(NPOLL), .POLL_GAP(GAP), .COEF_RST(RST_COEF)) i_ndiv_ramp_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ndiv_i(ndiv), .ramp_fin_i(fin),
    .busy_o(busy), .done_o(done), .err_o(err),
    .coef_o(coef), .stepa_o(stepa), .stepb_o(stepb), .slow_o(slow));

  initial forever begin
    @(negedge clk);
    if (!slow[31]) begin fin = 0; wcnt = 0; end
    else if (dly >= 0) begin
      if (wcnt >= dly) fin = 1; else wcnt++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(logic [7:0] n);
    @(negedge clk); ndiv = n; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 3000; k++) begin
      if (done || err) break;
      @(negedge clk);
    end
  endtask

  task automatic run(vec_t v, logic [31:0] prev);
    dly = v.dly;
    kick(v.n);
    wait_end();
    chk(v.e ? "R7 err" : "R6 done", {30'd0, err, done}, v.e ? 32'd2 : 32'd1);
    chk("R8 slow bits cleared", {slow[31], slow[22]}, 0);
    chk("R4 N written", coef[15:8], v.n);
    chk("R4 M/PL kept", {coef[31:16], coef[7:0]}, {prev[31:16], prev[7:0]});
    chk("R3 step A", stepa, 32'h2B00_0000);
    chk("R3 step B", stepb, 32'h000B_0000);
    @(negedge clk);
    chk("R9 idle after", {30'd0, busy, done | err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [31:0] c0, s0;
    repeat (3) @(negedge clk);
    chk("R1 flags", {busy, done, err}, 0);
    chk("R1 coef", coef, RST_COEF);
    chk("R1 regs", stepa | stepb | slow, 0);
    rst_n = 1;

    foreach (VECS[i]) run(VECS[i], coef);

    // R2: same N skips everything
    c0 = coef; s0 = slow;
    kick(8'h33);
    chk("R2 done pulse", {busy, done}, 32'd1);
    chk("R2 coef stable", coef, c0);
    chk("R2 slow stable", slow, s0);
    @(negedge clk);
    chk("R2 done one cycle", done, 0);

    // R9: start while busy is ignored
    dly = 30;
    kick(8'h50);
    chk("R9 busy", busy, 1);
    repeat (5) @(negedge clk);
    ndiv = 8'h60; start = 1; @(negedge clk); start = 0;
    wait_end();
    chk("R9 done", done, 1);
    chk("R9 N kept", coef[15:8], 8'h50);
    @(negedge clk);

    // R7: timeout latency
    dly = -1;
    kick(8'h22);
    while (!slow[31]) @(negedge clk);
    cnt = 0;
    while (!(err || done) && cnt < 5000) begin @(negedge clk); cnt++; end
    chk("R7 err", err, 1);
    chk("R7 latency", cnt, NPOLL*GAP + 1);
    chk("R8 cleared on err", {slow[31], slow[22]}, 0);
    chk("R7 N kept", coef[15:8], 8'h22);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule